// File: doc/BRIEF.md
# Gate-Drive Protection and Interlock Controller

This synchronous controller sits between the gate commands of a motor-control processor and the gate enables of a three-phase inverter with one boost power-factor-correction switch. Each of the six phase commands (a high and a low side for phases U, V and W) and the boost command is active high. Every command passes through a synchronizer and a minimum-width filter, then through a per-phase shoot-through interlock, before it reaches a registered gate output.

Protection inputs arrive as digitised flags. An over-current trip from the inverter or from the boost stage shuts every gate and pulls the fault line low. A low-side supply undervoltage does the same. These lockouts do not latch: once the cause is gone and a programmable clear interval has run out, the gates follow their commands again. A high-side undervoltage on one phase turns off only that phase's high-side gate and raises no fault. The shared enable line reads low to stop all gates without counting as a fault. The fault output models an open-drain pin: `flt_pull` = 1 means the pin is driven low, and 0 means it is released.

Top module: `gate_guard`

## Requirements
- R1: While reset is asserted, every gate output is 0 and `flt_pull` is 0 (pin released), whatever the inputs.
- R2: When the filtered high and low commands of one phase are both 1, both gate outputs of that phase are 0. Other phases are unaffected.
- R3: A 1 on `trip_inv` or `trip_pfc` drives all seven gate outputs to 0 and `flt_pull` to 1 within 4 clock cycles.
- R4: The lockout does not latch. After every trip and undervoltage flag has returned to 0, the gates stay off and `flt_pull` stays 1 for at least CLR_CYC cycles. The gates then follow the commands again with no other action, and `flt_pull` returns to 0.
- R5: While `uv_low` is 1, all gate outputs stay 0 and `flt_pull` stays 1 for the whole time. Release then follows R4.
- R6: A 1 on `uv_hi[p]` forces only `gate_hi[p]` to 0. It leaves the other gates alone and keeps `flt_pull` at 0.
- R7: While `en_in` is 0, all gate outputs are 0 and `flt_pull` stays 0. While `en_in` is 1, normal operation is allowed.
- R8: A command level that lasts fewer than FILT_CYC clock cycles, on or off, never reaches the gate outputs. A level held for FILT_CYC cycles or more does.
- R9: A new trip that arrives while the clear interval is counting restarts the interval from zero. The gates stay off for at least CLR_CYC cycles after the last trip is released.
- R10: With no fault, the enable high and no undervoltage flags set, each gate output equals its filtered command, subject to R2. Bit p of the phase vectors is phase U, V, W for p = 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_hi | input | 3 | High-side commands, bit 0 = U, 1 = V, 2 = W |
| cmd_lo | input | 3 | Low-side commands, same bit order |
| cmd_pfc | input | 1 | Boost switch command |
| en_in | input | 1 | Level read back from the shared enable/fault pin |
| trip_inv | input | 1 | Inverter over-current flag |
| trip_pfc | input | 1 | Boost-stage over-current flag |
| uv_low | input | 1 | Low-side supply undervoltage flag |
| uv_hi | input | 3 | Per-phase high-side undervoltage flags |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| gate_pfc | output | 1 | Boost gate enable |
| flt_pull | output | 1 | 1 = drive the fault pin low, 0 = release it |

## Verification
The bench builds the block with FILT_CYC = 4 and CLR_CYC = 20. At these values the pulses just under and just at the filter width can be driven directly. The full clear interval, and a trip that restarts it halfway through, also fit in a few dozen cycles. The short interval leaves room for hundreds of random command, enable and high-side undervoltage patterns, each held long enough for the gates to settle before they are compared with the expected levels.

// File: rtl/gg_pkg.sv
package gg_pkg;
  localparam int NPH = 3;

  // gate pair of one phase: {hi, lo}; allow folds in enable and lockout
  function automatic logic [1:0] leg_gates(input logic hi, input logic lo,
                                           input logic uvh, input logic allow);
    logic both;
    both = hi & lo;
    return {allow & hi & ~both & ~uvh, allow & lo & ~both};
  endfunction

  // true on the last cycle of a count that runs 0 .. lim-1
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction
endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gg_deglitch.sv
module gg_deglitch #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  import gg_pkg::*;
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;
  logic          differs;
  logic          accept;

  assign differs = din != dout;
  assign accept  = differs && at_last(int'(cnt), CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      cnt  <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (accept) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  filt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(din) != $past(dout)));
endmodule

// File: rtl/gg_lockout.sv
module gg_lockout #(
  parameter int CLR_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic lock
);
  import gg_pkg::*;
  localparam int CW = $clog2(CLR_CYC + 1);

  logic [CW-1:0] cnt;
  logic          blank;
  logic          expire;

  assign expire = blank && !hit && at_last(int'(cnt), CLR_CYC);
  assign lock   = hit | blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank <= 1'b0;
      cnt   <= '0;
    end else if (hit) begin
      blank <= 1'b1;
      cnt   <= '0;
    end else if (expire) begin
      blank <= 1'b0;
      cnt   <= '0;
    end else if (blank) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (blank && cnt == '0));
  // R4
  full_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> ($past(cnt) == CW'(CLR_CYC - 1) && !$past(hit)));
endmodule

// File: rtl/gate_guard.sv
module gate_guard #(
  parameter int FILT_CYC = 100,
  parameter int CLR_CYC  = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_hi,
  input  logic [2:0] cmd_lo,
  input  logic       cmd_pfc,
  input  logic       en_in,
  input  logic       trip_inv,
  input  logic       trip_pfc,
  input  logic       uv_low,
  input  logic [2:0] uv_hi,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       gate_pfc,
  output logic       flt_pull
);
  import gg_pkg::*;
  localparam int NCMD = 2 * NPH + 1;
  localparam int NPROT = NPH + 4;

  logic [NCMD-1:0]  cmd_s, cmd_f;
  logic [NPROT-1:0] prot_s;
  logic [NPH-1:0]   fhi, flo, uvh_s;
  logic             en_s, trip_s, uvl_s, hit, lock, allow;

  gg_sync #(.W(NCMD)) u_sync_cmd (
    .clk(clk), .rst_n(rst_n), .d({cmd_pfc, cmd_lo, cmd_hi}), .q(cmd_s));
  gg_sync #(.W(NPROT)) u_sync_prot (
    .clk(clk), .rst_n(rst_n),
    .d({uv_hi, uv_low, trip_pfc, trip_inv, en_in}), .q(prot_s));

  for (genvar i = 0; i < NCMD; i++) begin : g_filt
    gg_deglitch #(.CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(cmd_s[i]), .dout(cmd_f[i]));
  end

  assign fhi    = cmd_f[NPH-1:0];
  assign flo    = cmd_f[2*NPH-1:NPH];
  assign en_s   = prot_s[0];
  assign trip_s = prot_s[1] | prot_s[2];
  assign uvl_s  = prot_s[3];
  assign uvh_s  = prot_s[NPROT-1:4];
  assign hit    = trip_s | uvl_s;

  gg_lockout #(.CLR_CYC(CLR_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .hit(hit), .lock(lock));

  assign allow = en_s & ~lock;

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    logic [1:0] pair;
    assign pair = leg_gates(fhi[p], flo[p], uvh_s[p], allow);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_hi[p] <= 1'b0;
        gate_lo[p] <= 1'b0;
      end else begin
        gate_hi[p] <= pair[1];
        gate_lo[p] <= pair[0];
      end
    end

    // R2
    interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fhi[p] && flo[p]) |=> (!gate_hi[p] && !gate_lo[p]));
    // R6
    hs_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uvh_s[p] |=> !gate_hi[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_pfc <= 1'b0;
      flt_pull <= 1'b0;
    end else begin
      gate_pfc <= allow & cmd_f[NCMD-1];
      flt_pull <= lock;
    end
  end

  // R3
  lock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (gate_hi == '0 && gate_lo == '0 && !gate_pfc && flt_pull));
  // R5
  uv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvl_s |=> flt_pull);
  // R7
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (gate_hi == '0 && gate_lo == '0 && !gate_pfc));
  // R6
  no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !flt_pull);
endmodule

// File: tb/gate_guard_test.sv
`timescale 1ns/1ps
module gate_guard_test;
  localparam int F = 4;
  localparam int CLR = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ch = '0, cl = '0, uvh = '0;
  logic cp = 1'b0, en = 1'b1, ti = 1'b0, tp = 1'b0, uvl = 1'b0;
  logic [2:0] gh, gl;
  logic gp, fl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gate_guard #(.FILT_CYC(F), .CLR_CYC(CLR)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(ch), .cmd_lo(cl), .cmd_pfc(cp),
    .en_in(en), .trip_inv(ti), .trip_pfc(tp), .uv_low(uvl), .uv_hi(uvh),
    .gate_hi(gh), .gate_lo(gl), .gate_pfc(gp), .flt_pull(fl));

  function automatic logic [6:0] expect_gates(input logic [2:0] h, input logic [2:0] l,
                                              input logic p, input logic [2:0] u,
                                              input logic e);
    logic [2:0] eh, el;
    for (int i = 0; i < 3; i++) begin
      eh[i] = e && h[i] && !l[i] && !u[i];
      el[i] = e && l[i] && !h[i];
    end
    return {e && p, el, eh};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all_off(input string req, input logic fexp);
    chk({gp, gl, gh} == 7'd0, req, {gp, gl, gh}, 0);
    chk(fl == fexp, req, fl, fexp);
  endtask

  task automatic resume_count(output int n);
    n = 0;
    while (gp !== 1'b1 && n < 1000) begin
      tick(1);
      n++;
      if (n == CLR / 2) chk(fl == 1'b1, "R4 flag held during clear", fl, 1);
    end
  endtask

  initial begin
    int n;
    bit seen;
    logic [6:0] e;
    void'($urandom(32'd915));
    ch = 3'b111; cp = 1'b1;
    tick(4);
    // R1
    chk_all_off("R1 reset", 1'b0);
    ch = '0; cp = 1'b0;
    rst_n = 1'b1;
    tick(F + 6);
    chk_all_off("R1 after reset idle", 1'b0);

    // random command/enable/uv_hi patterns: R2 R6 R7 R10
    for (int k = 0; k < 300; k++) begin
      ch = 3'($urandom); cl = 3'($urandom); cp = 1'($urandom);
      uvh = ($urandom % 4 == 0) ? 3'($urandom) : 3'd0;
      en = ($urandom % 6 != 0);
      tick(F + 6);
      e = expect_gates(ch, cl, cp, uvh, en);
      chk({gp, gl, gh} == e, "R2 R6 R7 R10 random gates", {gp, gl, gh}, e);
      chk(fl == 1'b0, "R6 R7 no fault flag", fl, 0);
    end

    // directed R2
    en = 1; uvh = 0; ch = 3'b101; cl = 3'b001; cp = 0;
    tick(F + 6);
    chk(gh == 3'b100 && gl == 3'b000, "R2 phase U both on", {gh, gl}, 6'b100000);
    // directed R6
    ch = 3'b011; cl = 3'b100; uvh = 3'b010;
    tick(F + 6);
    chk(gh == 3'b001 && gl == 3'b100 && fl == 0, "R6 phase V uv", {fl, gh, gl}, 7'b0001100);
    uvh = 0;
    // directed R7
    en = 0; cp = 1;
    tick(8);
    chk_all_off("R7 enable low", 1'b0);
    en = 1;
    tick(F + 6);
    chk(gp == 1 && gh == 3'b011, "R7 enable restored", {gp, gh}, 4'b1011);

    // R3 inverter trip, then R4 release
    ti = 1;
    tick(4);
    chk_all_off("R3 inverter trip", 1'b1);
    tick(10);
    chk_all_off("R3 inverter trip held", 1'b1);
    ti = 0;
    resume_count(n);
    chk(n >= CLR && n <= CLR + 4, "R4 resume after inverter trip", n, CLR + 3);
    chk(fl == 0 && gh == 3'b011 && gl == 3'b100, "R4 gates follow again", {fl, gh, gl}, 7'b0011100);

    // R3 PFC trip
    tp = 1;
    tick(4);
    chk_all_off("R3 pfc trip", 1'b1);
    tp = 0;
    resume_count(n);
    chk(n >= CLR && n <= CLR + 4, "R4 resume after pfc trip", n, CLR + 3);

    // R9 restart during clear interval
    tp = 1; tick(3); tp = 0;
    tick(CLR / 2);
    chk_all_off("R9 still blank mid interval", 1'b1);
    ti = 1; tick(2); ti = 0;
    resume_count(n);
    chk(n >= CLR && n <= CLR + 4, "R9 full interval after retrip", n, CLR + 3);

    // R5 low-side undervoltage
    uvl = 1;
    tick(4);
    chk_all_off("R5 uv_low start", 1'b1);
    tick(3 * CLR);
    chk_all_off("R5 uv_low long", 1'b1);
    uvl = 0;
    resume_count(n);
    chk(n >= CLR && n <= CLR + 4, "R5 R4 resume after uv_low", n, CLR + 3);

    // R8 glitch filter on gate_pfc
    cp = 0; ch = 0; cl = 0;
    tick(F + 6);
    seen = 0;
    cp = 1; tick(F - 1); cp = 0;
    for (int i = 0; i < 15; i++) begin tick(1); if (gp) seen = 1; end
    chk(!seen, "R8 short on pulse dropped", seen, 0);
    seen = 0;
    cp = 1; tick(F); cp = 0;
    for (int i = 0; i < 15; i++) begin tick(1); if (gp) seen = 1; end
    chk(seen, "R8 full width on pulse passed", seen, 1);
    cp = 1; tick(F + 6);
    seen = 0;
    cp = 0; tick(F - 1); cp = 1;
    for (int i = 0; i < 15; i++) begin tick(1); if (!gp) seen = 1; end
    chk(!seen, "R8 short off pulse dropped", seen, 0);
    seen = 0;
    ch = 3'b010; tick(F - 1); ch = 0;
    for (int i = 0; i < 15; i++) begin tick(1); if (gh != 0) seen = 1; end
    chk(!seen, "R8 short high-side pulse dropped", seen, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule